// File: doc/BRIEF.md
# Snoop Ordering Decision Unit

This unit sits beside one active miss entry of a cache and decides what happens when a snoop hits that entry. It takes the entry's state and the snoop's attributes. From them it works out whether the snoop logically came before or after the request the entry has already sent. It then returns a verdict. The verdict says whether the snoop is handled here, and whether the entry must later invalidate or downgrade the copy it is waiting for. It also says whether upgrade requests held in the primary or deferred queue must be turned into full exclusive reads. Finally, it says whether the snoop must be queued as a target and replayed when the fill arrives, and which response marks go back on the snoop.

Snoops arrive on a valid/ready handshake. One snoop is accepted per cycle. The verdict for an accepted snoop appears on registered outputs for exactly one cycle, one clock after acceptance. The target queue itself is outside the unit. When the verdict needs a queue slot and the queue reports full, the unit holds ready low until a slot frees up.

Top module: `snoop_order_unit`

## Requirements
- R1: After reset, and in any cycle with `res_valid_o` low, every verdict output is 0.
- R2: If the entry is not in service, or the snoop is express while downstream-pending is set, the snoop precedes the entry's request. The verdict then has handled=0, both rewrite requests equal to the snoop's needs-writable, and every other output 0 except the attribute error.
- R3: If the snoop does not precede, the verdict has handled=1 and rewrites the deferred queue, but never the primary queue, exactly when the snoop needs writable.
- R4: A non-preceding snoop with post-invalidate already set enqueues nothing, sets neither post flag and asserts no mark.
- R5: A non-preceding snoop with post-invalidate clear is enqueued when pending-modified is set or the snoop is an invalidate. Its pending mark is downstream-pending AND the primary needs-writable flag, and it sets post-invalidate when it needs writable.
- R6: The cache-responding and had-writable marks are both set only when the snoop is enqueued, pending-modified is set, the snoop needs a response and it is not a plain invalidate command.
- R7: A non-preceding snoop with post-invalidate clear, which is cacheable and does not need writable, sets post-downgrade and the has-sharers mark.
- R8: While the snoop would be enqueued and `tgt_full_i` is high, `snp_ready_o` is low and no verdict is produced. Otherwise `snp_ready_o` is high.
- R9: `attr_err_o` is set in the verdict when the snoop's needs-writable and is-invalidate attributes differ. The rest of the verdict follows the rules above unchanged.
- R10: Each accepted snoop yields `res_valid_o` high for exactly one cycle, on the clock after acceptance. Back-to-back snoops yield back-to-back verdicts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_svc_i | input | 1 | Entry request has been issued |
| dn_pend_i | input | 1 | Entry request still buffered downstream |
| pend_mod_i | input | 1 | Entry awaits a writable copy |
| post_inv_i | input | 1 | An invalidation is already queued after the fill |
| prim_wr_i | input | 1 | Primary targets need writable |
| snp_valid_i | input | 1 | Snoop present |
| snp_ready_o | output | 1 | Snoop accepted this cycle when valid |
| snp_wr_i | input | 1 | Snoop needs writable |
| snp_inv_i | input | 1 | Snoop is an invalidation |
| snp_express_i | input | 1 | Snoop is express |
| snp_need_rsp_i | input | 1 | Snoop expects a response |
| snp_plain_inv_i | input | 1 | Snoop is a plain invalidate command |
| snp_uncache_i | input | 1 | Snoop is uncacheable |
| tgt_full_i | input | 1 | Target queue has no free slot |
| res_valid_o | output | 1 | Verdict valid |
| res_handled_o | output | 1 | Snoop handled by this entry |
| set_post_inv_o | output | 1 | Set post-invalidate |
| set_post_dng_o | output | 1 | Set post-downgrade |
| rw_prim_o | output | 1 | Rewrite upgrades in primary queue |
| rw_defer_o | output | 1 | Rewrite upgrades in deferred queue |
| enq_o | output | 1 | Enqueue snoop as primary target |
| enq_pend_o | output | 1 | Pending mark of enqueued target |
| mark_resp_o | output | 1 | Cache-responding mark on snoop |
| mark_had_wr_o | output | 1 | Responder-had-writable mark on snoop |
| mark_sharers_o | output | 1 | Has-sharers mark on snoop |
| attr_err_o | output | 1 | Needs-writable and invalidate attributes disagree |

## Verification
The hardest case to reach is a snoop that needs a queue slot while the queue is full. The handshake must then stall without losing or duplicating a verdict, and the snoop must be taken as soon as space appears. The bench holds valid with full raised over several edges, drops full while valid stays up, and checks that a single verdict follows. The express-while-downstream-pending ordering and the attribute-mismatch cases are also reached only by specific joint settings of entry state and snoop attributes. They are driven as explicit vectors.

// File: rtl/snoop_order_pkg.sv
package snoop_order_pkg;

  typedef struct packed {
    logic in_svc;
    logic dn_pend;
    logic pend_mod;
    logic post_inv;
    logic prim_wr;
  } entry_t;

  typedef struct packed {
    logic wr;
    logic inv;
    logic express;
    logic need_rsp;
    logic plain_inv;
    logic uncache;
  } snoop_t;

  typedef struct packed {
    logic handled;
    logic set_post_inv;
    logic set_post_dng;
    logic rw_prim;
    logic rw_defer;
    logic enq;
    logic enq_pend;
    logic mark_resp;
    logic mark_had_wr;
    logic mark_sharers;
    logic attr_err;
  } verdict_t;

  localparam int unsigned VerdictW = $bits(verdict_t);

endpackage

// File: rtl/snoop_order_decide.sv
module snoop_order_decide
  import snoop_order_pkg::*;
(
  input  entry_t   entry_i,
  input  snoop_t   snoop_i,
  output verdict_t verdict_o
);

  logic precede;
  logic replay;
  logic respond;
  logic downgrade;

  // snoop ordered ahead of our own request
  assign precede   = !entry_i.in_svc || (snoop_i.express && entry_i.dn_pend);
  assign replay    = !entry_i.post_inv && (entry_i.pend_mod || snoop_i.inv);
  assign respond   = replay && entry_i.pend_mod && snoop_i.need_rsp && !snoop_i.plain_inv;
  assign downgrade = !entry_i.post_inv && !snoop_i.wr && !snoop_i.uncache;

  always_comb begin
    verdict_o          = '0;
    verdict_o.attr_err = snoop_i.wr ^ snoop_i.inv;
    if (precede) begin
      verdict_o.rw_prim  = snoop_i.wr;
      verdict_o.rw_defer = snoop_i.wr;
    end else begin
      verdict_o.handled  = 1'b1;
      verdict_o.rw_defer = snoop_i.wr;
      if (replay) begin
        verdict_o.enq          = 1'b1;
        verdict_o.enq_pend     = entry_i.dn_pend && entry_i.prim_wr;
        verdict_o.set_post_inv = snoop_i.wr;
      end
      if (respond) begin
        verdict_o.mark_resp   = 1'b1;
        verdict_o.mark_had_wr = 1'b1;
      end
      if (downgrade) begin
        verdict_o.set_post_dng = 1'b1;
        verdict_o.mark_sharers = 1'b1;
      end
    end
  end

endmodule

// File: rtl/snoop_order_reg.sv
module snoop_order_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         d_valid_i,
  input  logic [W-1:0] d_data_i,
  output logic         q_valid_o,
  output logic [W-1:0] q_data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_valid_o <= 1'b0;
      q_data_o  <= '0;
    end else begin
      q_valid_o <= d_valid_i;
      q_data_o  <= d_valid_i ? d_data_i : '0;
    end
  end

endmodule

// File: rtl/snoop_order_unit.sv
module snoop_order_unit
  import snoop_order_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_svc_i,
  input  logic dn_pend_i,
  input  logic pend_mod_i,
  input  logic post_inv_i,
  input  logic prim_wr_i,
  input  logic snp_valid_i,
  output logic snp_ready_o,
  input  logic snp_wr_i,
  input  logic snp_inv_i,
  input  logic snp_express_i,
  input  logic snp_need_rsp_i,
  input  logic snp_plain_inv_i,
  input  logic snp_uncache_i,
  input  logic tgt_full_i,
  output logic res_valid_o,
  output logic res_handled_o,
  output logic set_post_inv_o,
  output logic set_post_dng_o,
  output logic rw_prim_o,
  output logic rw_defer_o,
  output logic enq_o,
  output logic enq_pend_o,
  output logic mark_resp_o,
  output logic mark_had_wr_o,
  output logic mark_sharers_o,
  output logic attr_err_o
);

  entry_t   entry;
  snoop_t   snoop;
  verdict_t verdict;
  verdict_t verdict_q;
  logic     fire;

  assign entry = '{in_svc: in_svc_i, dn_pend: dn_pend_i, pend_mod: pend_mod_i,
                   post_inv: post_inv_i, prim_wr: prim_wr_i};
  assign snoop = '{wr: snp_wr_i, inv: snp_inv_i, express: snp_express_i,
                   need_rsp: snp_need_rsp_i, plain_inv: snp_plain_inv_i,
                   uncache: snp_uncache_i};

  snoop_order_decide u_decide (
    .entry_i   (entry),
    .snoop_i   (snoop),
    .verdict_o (verdict)
  );

  // stall only when a queue slot is needed and none is free
  assign snp_ready_o = !(verdict.enq && tgt_full_i);
  assign fire        = snp_valid_i && snp_ready_o;

  snoop_order_reg #(.W(VerdictW)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .d_valid_i (fire),
    .d_data_i  (verdict),
    .q_valid_o (res_valid_o),
    .q_data_o  (verdict_q)
  );

  assign res_handled_o  = verdict_q.handled;
  assign set_post_inv_o = verdict_q.set_post_inv;
  assign set_post_dng_o = verdict_q.set_post_dng;
  assign rw_prim_o      = verdict_q.rw_prim;
  assign rw_defer_o     = verdict_q.rw_defer;
  assign enq_o          = verdict_q.enq;
  assign enq_pend_o     = verdict_q.enq_pend;
  assign mark_resp_o    = verdict_q.mark_resp;
  assign mark_had_wr_o  = verdict_q.mark_had_wr;
  assign mark_sharers_o = verdict_q.mark_sharers;
  assign attr_err_o     = verdict_q.attr_err;

endmodule

// File: rtl/snoop_order_chk.sv
module snoop_order_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic in_svc_i,
  input logic dn_pend_i,
  input logic pend_mod_i,
  input logic post_inv_i,
  input logic snp_valid_i,
  input logic snp_ready_o,
  input logic snp_wr_i,
  input logic snp_inv_i,
  input logic snp_express_i,
  input logic tgt_full_i,
  input logic res_valid_o,
  input logic res_handled_o,
  input logic set_post_inv_o,
  input logic set_post_dng_o,
  input logic enq_o,
  input logic mark_resp_o,
  input logic mark_had_wr_o,
  input logic mark_sharers_o,
  input logic attr_err_o
);

  logic after_us;
  assign after_us = in_svc_i && !(snp_express_i && dn_pend_i);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> !(res_handled_o || enq_o || mark_resp_o || set_post_inv_o || attr_err_o));

  a_r10_follows_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(snp_valid_i && snp_ready_o));

  a_r2_precede_unhandled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_ready_o && !in_svc_i) |=> (res_valid_o && !res_handled_o && !enq_o));

  a_r4_post_inv_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_ready_o && after_us && post_inv_i) |=>
      (res_handled_o && !enq_o && !set_post_inv_o && !set_post_dng_o && !mark_sharers_o));

  a_r6_resp_needs_enq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && mark_resp_o) |-> (enq_o && mark_had_wr_o));

  a_r8_full_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && tgt_full_i && after_us && !post_inv_i && (pend_mod_i || snp_inv_i))
      |-> !snp_ready_o);

  a_r9_attr_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_ready_o && (snp_wr_i != snp_inv_i)) |=> attr_err_o);

endmodule

bind snoop_order_unit snoop_order_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .in_svc_i       (in_svc_i),
  .dn_pend_i      (dn_pend_i),
  .pend_mod_i     (pend_mod_i),
  .post_inv_i     (post_inv_i),
  .snp_valid_i    (snp_valid_i),
  .snp_ready_o    (snp_ready_o),
  .snp_wr_i       (snp_wr_i),
  .snp_inv_i      (snp_inv_i),
  .snp_express_i  (snp_express_i),
  .tgt_full_i     (tgt_full_i),
  .res_valid_o    (res_valid_o),
  .res_handled_o  (res_handled_o),
  .set_post_inv_o (set_post_inv_o),
  .set_post_dng_o (set_post_dng_o),
  .enq_o          (enq_o),
  .mark_resp_o    (mark_resp_o),
  .mark_had_wr_o  (mark_had_wr_o),
  .mark_sharers_o (mark_sharers_o),
  .attr_err_o     (attr_err_o)
);

// File: tb/tb_snoop_order_unit.sv
`timescale 1ns/1ps
module tb_snoop_order_unit;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_svc, dn_pend, pend_mod, post_inv, prim_wr;
  logic snp_valid, snp_ready;
  logic snp_wr, snp_inv, snp_express, snp_need_rsp, snp_plain_inv, snp_uncache;
  logic tgt_full;
  logic res_valid, res_handled, set_post_inv, set_post_dng, rw_prim, rw_defer;
  logic enq, enq_pend, mark_resp, mark_had_wr, mark_sharers, attr_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  snoop_order_unit dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_svc_i(in_svc), .dn_pend_i(dn_pend), .pend_mod_i(pend_mod),
    .post_inv_i(post_inv), .prim_wr_i(prim_wr),
    .snp_valid_i(snp_valid), .snp_ready_o(snp_ready),
    .snp_wr_i(snp_wr), .snp_inv_i(snp_inv), .snp_express_i(snp_express),
    .snp_need_rsp_i(snp_need_rsp), .snp_plain_inv_i(snp_plain_inv),
    .snp_uncache_i(snp_uncache), .tgt_full_i(tgt_full),
    .res_valid_o(res_valid), .res_handled_o(res_handled),
    .set_post_inv_o(set_post_inv), .set_post_dng_o(set_post_dng),
    .rw_prim_o(rw_prim), .rw_defer_o(rw_defer), .enq_o(enq),
    .enq_pend_o(enq_pend), .mark_resp_o(mark_resp), .mark_had_wr_o(mark_had_wr),
    .mark_sharers_o(mark_sharers), .attr_err_o(attr_err)
  );

  // in:  svc dn pm pi pw | wr inv ex nr pl un
  // exp: h spi spd rwp rwd enq ep rsp hw sh err
  localparam int NV = 14;
  localparam logic [21:0] VEC [NV] = '{
    {11'b00000_110000, 11'b00011000000},
    {11'b00000_000000, 11'b00000000000},
    {11'b11000_111000, 11'b00011000000},
    {11'b10010_110000, 11'b10001000000},
    {11'b11101_000100, 11'b10100111110},
    {11'b10101_110100, 11'b11001101100},
    {11'b10100_110110, 11'b11001100000},
    {11'b10000_110100, 11'b11001100000},
    {11'b10000_000000, 11'b10100000010},
    {11'b10000_000001, 11'b10000000000},
    {11'b11100_000000, 11'b10100100010},
    {11'b10000_100000, 11'b10001000001},
    {11'b10000_010000, 11'b10100100011},
    {11'b10000_111000, 11'b11001100000}
  };

  function automatic logic [10:0] verdict();
    return {res_handled, set_post_inv, set_post_dng, rw_prim, rw_defer, enq,
            enq_pend, mark_resp, mark_had_wr, mark_sharers, attr_err};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [10:0] v);
    {in_svc, dn_pend, pend_mod, post_inv, prim_wr,
     snp_wr, snp_inv, snp_express, snp_need_rsp, snp_plain_inv, snp_uncache} = v;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    snp_valid = 1'b0;
    tgt_full  = 1'b0;
    drive(11'b0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset valid", 32'(res_valid), 32'd0);
    chk("R1 reset verdict", 32'(verdict()), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 idle verdict", 32'(verdict()), 32'd0);

    // table: R2 R3 R4 R5 R6 R7 R9 R10
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][21:11]);
      snp_valid = 1'b1;
      @(negedge clk);
      snp_valid = 1'b0;
      chk($sformatf("R10 vec %0d valid", i), 32'(res_valid), 32'd1);
      chk($sformatf("R2 R3 R4 R5 R6 R7 R9 vec %0d", i), 32'(verdict()), 32'(VEC[i][10:0]));
    end
    @(negedge clk);
    chk("R10 single pulse", 32'(res_valid), 32'd0);
    chk("R1 quiet after pulse", 32'(verdict()), 32'd0);

    // R8 stall while full on an enqueuing snoop
    drive(VEC[4][21:11]);
    tgt_full  = 1'b1;
    snp_valid = 1'b1;
    #1;
    chk("R8 ready low", 32'(snp_ready), 32'd0);
    @(negedge clk);
    chk("R8 no verdict while stalled", 32'(res_valid), 32'd0);
    @(negedge clk);
    chk("R8 still stalled", 32'(res_valid), 32'd0);
    tgt_full = 1'b0;
    #1;
    chk("R8 ready on space", 32'(snp_ready), 32'd1);
    @(negedge clk);
    snp_valid = 1'b0;
    chk("R8 verdict after space", 32'(res_valid), 32'd1);
    chk("R8 verdict content", 32'(verdict()), 32'(VEC[4][10:0]));
    @(negedge clk);
    chk("R10 one verdict per snoop", 32'(res_valid), 32'd0);

    // R8 full does not stall non-enqueuing snoops
    tgt_full = 1'b1;
    drive(VEC[8][21:11]);
    #1;
    chk("R8 downgrade not stalled", 32'(snp_ready), 32'd1);
    drive(VEC[0][21:11]);
    #1;
    chk("R8 preceding not stalled", 32'(snp_ready), 32'd1);
    tgt_full = 1'b0;

    // R10 back-to-back
    drive(VEC[8][21:11]);
    snp_valid = 1'b1;
    @(negedge clk);
    drive(VEC[0][21:11]);
    chk("R10 b2b first valid", 32'(res_valid), 32'd1);
    chk("R10 b2b first verdict", 32'(verdict()), 32'(VEC[8][10:0]));
    @(negedge clk);
    snp_valid = 1'b0;
    chk("R10 b2b second valid", 32'(res_valid), 32'd1);
    chk("R10 b2b second verdict", 32'(verdict()), 32'(VEC[0][10:0]));
    @(negedge clk);
    chk("R10 b2b end", 32'(res_valid), 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule